// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block keeps the tag and metadata side of a set-associative cache with 64-byte lines and carries no data payload. Each accepted request is a read or a write to a 64-bit byte address. The block looks the line up, reports hit or miss, allocates on every miss, maintains the replacement order of the set, keeps per-way dirty bits, and counts the memory traffic the cache would cause.

Two run-time inputs pick the replacement policy (least recently used or first in, first out) and the write policy (write-through or write-back). The number of sets and ways are elaboration parameters, so capacity is sets × ways × 64 bytes. Five counters report accesses, hits, misses, line fills read from memory, and writes to memory; the miss ratio is formed from the miss and access counts. A flush command walks every set and charges one memory write per dirty valid line. A synchronous clear returns all metadata and counters to their initial state.

Top module: `cache_tag_ctrl`

## Requirements
- R1: The line address is the byte address divided by 64 (bits 63:6). The set index is the line address modulo SETS, and the stored tag is the full 58-bit line address, so two addresses that differ only in bit 63 never hit each other, while two addresses within one 64-byte line always do.
- R2: When idle, req_ready_o is high. A request is accepted on a clock edge where req_valid_i and req_ready_o are both high. rsp_valid_o is then high for exactly the following cycle, and rsp_hit_o gives the lookup result.
- R3: Every accepted request increments the access counter by one, and increments exactly one of the hit or miss counters.
- R4: On a miss, an invalid way of the set is filled (the lowest-numbered invalid way first) before any valid way is evicted.
- R5: With repl_fifo_i = 0, replacement is LRU. A hit or fill makes the way the most recent, and a miss in a full set evicts the least recently used way.
- R6: With repl_fifo_i = 1, replacement is FIFO. A hit leaves the order unchanged, and a miss in a full set evicts the earliest filled way.
- R7: Every miss, read or write, allocates the line and increments the memory-read counter by one.
- R8: With wr_back_i = 0, write-through is in force. Every accepted write, hit or miss, increments the memory-write counter by one, and no line is marked dirty.
- R9: With wr_back_i = 1, write-back is in force. A write marks its line dirty without memory traffic. Evicting a dirty line increments the memory-write counter by one.
- R10: A flush_i pulse while idle starts a walk of one set per cycle. During the walk req_ready_o is low, one memory write is counted for each dirty valid line, and dirty bits are cleared (lines stay valid). flush_done_o is a one-cycle pulse SETS cycles after the walk starts. A flush_i during a walk is ignored.
- R11: clear_i synchronously invalidates every line, clears dirty bits, restores the initial replacement order and zeroes all counters. It takes priority over requests and flushes.
- R12: After reset, all counters are zero, no line is valid, rsp_valid_o and flush_done_o are low, and req_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of metadata and counters |
| repl_fifo_i | input | 1 | Replacement policy: 0 LRU, 1 FIFO |
| wr_back_i | input | 1 | Write policy: 0 write-through, 1 write-back |
| req_valid_i | input | 1 | Request valid |
| req_write_i | input | 1 | Request is a write (0 = read) |
| req_addr_i | input | 64 | Request byte address |
| req_ready_o | output | 1 | Block can accept a request |
| rsp_valid_o | output | 1 | Response valid, one cycle after acceptance |
| rsp_hit_o | output | 1 | Response: 1 hit, 0 miss |
| flush_i | input | 1 | Start a flush walk |
| flush_done_o | output | 1 | One-cycle pulse at the end of a flush walk |
| cnt_access_o | output | CNT_W | Accepted requests |
| cnt_hit_o | output | CNT_W | Hits |
| cnt_miss_o | output | CNT_W | Misses |
| cnt_mem_rd_o | output | CNT_W | Line fills read from memory |
| cnt_mem_wr_o | output | CNT_W | Writes to memory |

## Verification
The assertions assume the counters never wrap within a run. They also assume that a request arrives only while req_ready_o is high, so that no request coincides with clear_i, flush_i or a walk. The stimulus keeps well below 2^32 accesses and drives req_valid_i only at negative edges when the block is idle, never in the same cycle as a clear or flush pulse. Random addresses come from a small pool of tags spread over four sets, and some of them have bit 63 set. This keeps conflict evictions, aliasing checks and mode switches frequent.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  localparam int unsigned ADDR_W   = 64;
  localparam int unsigned OFFSET_W = 6;
  localparam int unsigned TAG_W    = ADDR_W - OFFSET_W;
  localparam int unsigned NUM_CNT  = 5;
  localparam int unsigned CI_ACC   = 0;
  localparam int unsigned CI_HIT   = 1;
  localparam int unsigned CI_MISS  = 2;
  localparam int unsigned CI_RD    = 3;
  localparam int unsigned CI_WR    = 4;
  typedef logic [TAG_W-1:0] tag_t;
endpackage

// File: rtl/cache_lookup.sv
module cache_lookup
  import cache_tag_pkg::*;
#(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WAY_IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0]     tags_i,
  input  logic [WAYS-1:0]                valid_i,
  input  logic [WAYS-1:0]                dirty_i,
  input  logic [WAYS-1:0][WAY_IDX_W-1:0] rank_i,
  input  tag_t                           tag_i,
  output logic [WAYS-1:0]                match_o,
  output logic                           hit_o,
  output logic [WAY_IDX_W-1:0]           way_o,
  output logic                           victim_dirty_o
);
  logic [WAY_IDX_W-1:0] hit_way, free_way, old_way;
  logic                 any_free;

  always_comb begin
    match_o  = '0;
    hit_way  = '0;
    old_way  = '0;
    free_way = '0;
    any_free = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      match_o[w] = valid_i[w] && (tags_i[w] == tag_i);
      if (match_o[w]) hit_way = WAY_IDX_W'(w);
      if (rank_i[w] == WAY_IDX_W'(WAYS - 1)) old_way = WAY_IDX_W'(w);
    end
    // lowest-numbered invalid way wins
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        any_free = 1'b1;
        free_way = WAY_IDX_W'(w);
      end
    end
  end

  assign hit_o          = |match_o;
  assign way_o          = hit_o ? hit_way : (any_free ? free_way : old_way);
  assign victim_dirty_o = !hit_o && valid_i[way_o] && dirty_i[way_o];
endmodule

// File: rtl/cache_rank_upd.sv
module cache_rank_upd #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WAY_IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][WAY_IDX_W-1:0] rank_i,
  input  logic [WAY_IDX_W-1:0]           way_i,
  input  logic                           en_i,
  output logic [WAYS-1:0][WAY_IDX_W-1:0] rank_o
);
  logic [WAY_IDX_W-1:0] sel_rank;
  assign sel_rank = rank_i[way_i];

  // rank 0 = newest; only ways younger than the selected one age
  always_comb begin
    rank_o = rank_i;
    if (en_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_IDX_W'(w) == way_i)     rank_o[w] = '0;
        else if (rank_i[w] < sel_rank)  rank_o[w] = rank_i[w] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cache_stat_cnt.sv
module cache_stat_cnt #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned INC_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + CNT_W'(inc_i);
  end
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import cache_tag_pkg::*;
#(
  parameter int unsigned SETS  = 16,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              repl_fifo_i,
  input  logic              wr_back_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  input  logic              flush_i,
  output logic              flush_done_o,
  output logic [CNT_W-1:0]  cnt_access_o,
  output logic [CNT_W-1:0]  cnt_hit_o,
  output logic [CNT_W-1:0]  cnt_miss_o,
  output logic [CNT_W-1:0]  cnt_mem_rd_o,
  output logic [CNT_W-1:0]  cnt_mem_wr_o
);
  localparam int unsigned SET_W     = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int unsigned WAY_IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int unsigned INC_W     = $clog2(WAYS + 1) + 1;

  logic [WAYS-1:0][TAG_W-1:0]     tag_q   [SETS];
  logic [WAYS-1:0]                valid_q [SETS];
  logic [WAYS-1:0]                dirty_q [SETS];
  logic [WAYS-1:0][WAY_IDX_W-1:0] rank_q  [SETS];

  tag_t                           req_tag;
  logic [SET_W-1:0]               req_set;
  logic                           accept;
  logic [WAYS-1:0]                lk_match;
  logic                           lk_hit, lk_vdirty;
  logic [WAY_IDX_W-1:0]           lk_way;
  logic [WAYS-1:0][WAY_IDX_W-1:0] rank_new;
  logic                           flush_busy_q, flush_done_q, rsp_valid_q, rsp_hit_q;
  logic [SET_W-1:0]               flush_ptr_q;
  logic [INC_W-1:0]               inc [NUM_CNT];
  logic [CNT_W-1:0]               cnt [NUM_CNT];
  logic                           unused_offset;

  assign req_tag       = req_addr_i[ADDR_W-1:OFFSET_W];
  assign unused_offset = ^req_addr_i[OFFSET_W-1:0];

  generate
    if (SETS > 1) begin : g_idx
      assign req_set = req_tag[SET_W-1:0];
    end else begin : g_one_set
      assign req_set = '0;
    end
  endgenerate

  assign req_ready_o = !flush_busy_q && !flush_i && !clear_i;
  assign accept      = req_valid_i && req_ready_o;

  cache_lookup #(.WAYS(WAYS)) u_lookup (
    .tags_i         (tag_q[req_set]),
    .valid_i        (valid_q[req_set]),
    .dirty_i        (dirty_q[req_set]),
    .rank_i         (rank_q[req_set]),
    .tag_i          (req_tag),
    .match_o        (lk_match),
    .hit_o          (lk_hit),
    .way_o          (lk_way),
    .victim_dirty_o (lk_vdirty)
  );

  cache_rank_upd #(.WAYS(WAYS)) u_rank (
    .rank_i (rank_q[req_set]),
    .way_i  (lk_way),
    .en_i   (accept && (!lk_hit || !repl_fifo_i)),
    .rank_o (rank_new)
  );

  always_ff @(posedge clk_i) begin
    if (accept && !lk_hit) tag_q[req_set][lk_way] <= req_tag;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || clear_i) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) rank_q[s][w] <= WAY_IDX_W'(w);
      end
      flush_busy_q <= 1'b0;
      flush_done_q <= 1'b0;
      flush_ptr_q  <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_hit_q    <= 1'b0;
    end else begin
      rsp_valid_q  <= accept;
      flush_done_q <= 1'b0;
      if (accept) begin
        rsp_hit_q       <= lk_hit;
        rank_q[req_set] <= rank_new;
        if (!lk_hit) begin
          valid_q[req_set][lk_way] <= 1'b1;
          dirty_q[req_set][lk_way] <= req_write_i && wr_back_i;
        end else if (req_write_i && wr_back_i) begin
          dirty_q[req_set][lk_way] <= 1'b1;
        end
      end
      if (flush_busy_q) begin
        dirty_q[flush_ptr_q] <= '0;
        if (flush_ptr_q == SET_W'(SETS - 1)) begin
          flush_busy_q <= 1'b0;
          flush_done_q <= 1'b1;
        end else begin
          flush_ptr_q <= flush_ptr_q + 1'b1;
        end
      end else if (flush_i) begin
        flush_busy_q <= 1'b1;
        flush_ptr_q  <= '0;
      end
    end
  end

  assign inc[CI_ACC]  = INC_W'(accept);
  assign inc[CI_HIT]  = INC_W'(accept && lk_hit);
  assign inc[CI_MISS] = INC_W'(accept && !lk_hit);
  assign inc[CI_RD]   = INC_W'(accept && !lk_hit);
  assign inc[CI_WR]   = accept ? INC_W'(req_write_i && !wr_back_i) + INC_W'(lk_vdirty)
                      : flush_busy_q ? INC_W'($countones(valid_q[flush_ptr_q] & dirty_q[flush_ptr_q]))
                      : '0;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    cache_stat_cnt #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clear_i),
      .inc_i (inc[g]),
      .cnt_o (cnt[g])
    );
  end

  assign cnt_access_o = cnt[CI_ACC];
  assign cnt_hit_o    = cnt[CI_HIT];
  assign cnt_miss_o   = cnt[CI_MISS];
  assign cnt_mem_rd_o = cnt[CI_RD];
  assign cnt_mem_wr_o = cnt[CI_WR];
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_hit_o    = rsp_hit_q;
  assign flush_done_o = flush_done_q;

  a_r1_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match));
  a_r2_rsp_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> rsp_valid_o);
  a_r3_access_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_access_o == cnt_hit_o + cnt_miss_o);
  a_r7_fill_per_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_mem_rd_o == cnt_miss_o);
  a_r8_wt_write_traffic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && req_write_i && !wr_back_i) |=> (cnt_mem_wr_o != $past(cnt_mem_wr_o)));
  a_r9_wb_hit_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && lk_hit && wr_back_i && !clear_i) |=> $stable(cnt_mem_wr_o));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_done_o |=> !flush_done_o);
endmodule

// File: tb/cache_tag_ctrl_tb.sv
`timescale 1ns/1ps
module cache_tag_ctrl_tb;
  localparam int SETS = 16;
  localparam int WAYS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0, fifo = 1'b0, wb = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, flush = 1'b0;
  logic [63:0] req_addr = '0;
  logic        ready, rsp_valid, rsp_hit, flush_done;
  logic [31:0] c_acc, c_hit, c_miss, c_rd, c_wr;

  int checks = 0, fails = 0;

  // reference model: per-set order list, index 0 = newest
  logic [57:0] m_tag [SETS][WAYS];
  bit          m_val [SETS][WAYS];
  bit          m_dty [SETS][WAYS];
  int          m_ord [SETS][WAYS];
  longint      m_acc, m_hit, m_miss, m_rd, m_wr;

  always #2 clk = ~clk;

  cache_tag_ctrl #(.SETS(SETS), .WAYS(WAYS), .CNT_W(32)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .repl_fifo_i(fifo), .wr_back_i(wb),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_ready_o(ready), .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit),
    .flush_i(flush), .flush_done_o(flush_done),
    .cnt_access_o(c_acc), .cnt_hit_o(c_hit), .cnt_miss_o(c_miss),
    .cnt_mem_rd_o(c_rd), .cnt_mem_wr_o(c_wr)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void m_clear();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_val[s][w] = 0; m_dty[s][w] = 0; m_ord[s][w] = w;
      end
    m_acc = 0; m_hit = 0; m_miss = 0; m_rd = 0; m_wr = 0;
  endfunction

  function automatic void m_promote(int s, int w);
    int p = 0;
    for (int k = 0; k < WAYS; k++) if (m_ord[s][k] == w) p = k;
    for (int k = p; k > 0; k--) m_ord[s][k] = m_ord[s][k-1];
    m_ord[s][0] = w;
  endfunction

  function automatic bit m_access(bit wr, logic [63:0] a);
    logic [57:0] t = a[63:6];
    int s = int'(t % SETS);
    int h = -1;
    int v = -1;
    m_acc++;
    for (int w = 0; w < WAYS; w++) if (m_val[s][w] && m_tag[s][w] == t) h = w;
    if (wr && !wb) m_wr++;
    if (h >= 0) begin
      m_hit++;
      if (!fifo) m_promote(s, h);
      if (wr && wb) m_dty[s][h] = 1;
      return 1'b1;
    end
    m_miss++; m_rd++;
    for (int w = WAYS - 1; w >= 0; w--) if (!m_val[s][w]) v = w;
    if (v < 0) v = m_ord[s][WAYS-1];
    if (m_val[s][v] && m_dty[s][v]) m_wr++;
    m_tag[s][v] = t; m_val[s][v] = 1; m_dty[s][v] = wr && wb;
    m_promote(s, v);
    return 1'b0;
  endfunction

  function automatic logic [63:0] mk(longint hi, int set, int off);
    return {hi[53:0], 4'(set), 6'(off)};
  endfunction

  // returns the observed hit; compares against the model
  task automatic access(string req, bit wr, logic [63:0] a, output bit hit_seen);
    bit exp;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    exp = m_access(wr, a);
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " rsp_valid"}, rsp_valid, 1);
    check({req, " hit"}, rsp_hit, exp);
    hit_seen = rsp_hit;
  endtask

  task automatic check_cnts(string req);
    check({req, " access"}, c_acc, m_acc);
    check({req, " hits"},   c_hit, m_hit);
    check({req, " misses"}, c_miss, m_miss);
    check({req, " mem_rd"}, c_rd, m_rd);
    check({req, " mem_wr"}, c_wr, m_wr);
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    m_clear();
  endtask

  task automatic do_flush(string req);
    int n = 0;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    check({req, " ready low in walk"}, ready, 0);
    while (!flush_done && n < SETS + 4) begin
      @(negedge clk); n++;
    end
    check({req, " walk length"}, n, SETS);
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        if (m_val[s][w] && m_dty[s][w]) begin m_wr++; m_dty[s][w] = 0; end
    @(negedge clk);
    check({req, " done is a pulse"}, flush_done, 0);
    check({req, " ready after walk"}, ready, 1);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit h;
    void'($urandom(32'h5eed_c0de));
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 ready", ready, 1);
    check("R12 rsp_valid", rsp_valid, 0);
    check("R12 flush_done", flush_done, 0);
    check_cnts("R12");

    // R1 / R2 index, full tag, handshake
    fifo = 0; wb = 1;
    access("R2 first read", 0, mk(1, 0, 0), h);
    access("R2 repeat", 0, mk(1, 0, 0), h);
    check("R2 repeat hits", h, 1);
    access("R1 same line other byte", 0, mk(1, 0, 37), h);
    check("R1 same line hits", h, 1);
    access("R1 bit63 alias", 0, mk(1, 0, 0) | (64'd1 << 63), h);
    check("R1 bit63 misses", h, 0);
    @(negedge clk);
    check("R2 rsp_valid one cycle", rsp_valid, 0);
    check_cnts("R3 after R1");

    // R4 fill invalid ways first, R5 LRU
    do_clear();
    check_cnts("R11 after clear");
    for (int i = 1; i <= 4; i++) access("R4 fill", 0, mk(i, 3, 0), h);
    for (int i = 1; i <= 4; i++) begin
      access("R4 all kept", 0, mk(i, 3, 0), h);
      check("R4 filled way retained", h, 1);
    end
    access("R5 touch A", 0, mk(1, 3, 0), h);
    access("R5 new E", 0, mk(5, 3, 0), h);
    access("R5 B evicted", 0, mk(2, 3, 0), h);
    check("R5 lru victim", h, 0);
    access("R5 A kept", 0, mk(1, 3, 0), h);
    check("R5 recent kept", h, 1);

    // R6 FIFO
    do_clear();
    fifo = 1;
    for (int i = 1; i <= 4; i++) access("R6 fill", 0, mk(i, 5, 0), h);
    access("R6 touch A", 0, mk(1, 5, 0), h);
    access("R6 new E", 0, mk(5, 5, 0), h);
    access("R6 A evicted", 0, mk(1, 5, 0), h);
    check("R6 oldest fill evicted", h, 0);
    access("R6 D kept", 0, mk(4, 5, 0), h);
    check("R6 D hit", h, 1);
    check_cnts("R7 after fifo");

    // R8 write-through
    do_clear();
    fifo = 0; wb = 0;
    access("R8 write miss", 1, mk(1, 6, 0), h);
    access("R8 write hit", 1, mk(1, 6, 0), h);
    access("R8 read hit", 0, mk(1, 6, 0), h);
    check("R8 mem_wr", c_wr, 2);
    check("R7 mem_rd", c_rd, 1);
    do_flush("R8 flush no dirty");
    check("R8 no dirty lines", c_wr, 2);

    // R9 write-back, R10 flush
    do_clear();
    wb = 1;
    for (int i = 1; i <= 4; i++) access("R9 dirty fill", 1, mk(i, 7, 0), h);
    check("R9 no write yet", c_wr, 0);
    access("R9 evict A", 0, mk(5, 7, 0), h);
    check("R9 dirty evict", c_wr, 1);
    access("R9 evict B", 0, mk(6, 7, 0), h);
    check("R9 dirty evict 2", c_wr, 2);
    access("R9 write hit", 1, mk(6, 7, 0), h);
    check("R9 write hit silent", c_wr, 2);
    do_flush("R10");
    check("R10 flush writes", c_wr, 5);
    access("R10 still valid", 0, mk(3, 7, 0), h);
    check("R10 line kept", h, 1);
    access("R10 evict cleaned", 0, mk(8, 7, 0), h);
    access("R10 evict cleaned 2", 0, mk(9, 7, 0), h);
    check("R10 cleaned evict no write", c_wr, 5);
    check_cnts("R10");

    // R11 clear
    do_clear();
    check_cnts("R11");
    access("R11 line gone", 0, mk(3, 7, 0), h);
    check("R11 invalidated", h, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a;
      if (i % 250 == 0) begin
        fifo = $urandom_range(0, 1);
        wb   = $urandom_range(0, 1);
      end
      a = mk($urandom_range(0, 5), $urandom_range(0, 3), $urandom_range(0, 63));
      if ($urandom_range(0, 7) == 0) a[63] = 1'b1;
      access("R5 R6 R9 random", $urandom_range(0, 1), a, h);
      if (i % 400 == 399) do_flush("R10 random");
      if (i % 100 == 99) check_cnts("R3 R7 R8 random");
    end
    check_cnts("R3 final");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule